// File: doc/BRIEF.md
# Linear Sensor Readout Sequencer

This block is the digital sequencer of a linear image sensor with a parameterised pixel count (256 by default). A start request sampled on a rising clock edge begins a readout. The block then steps a pixel-select index through every pixel, one pixel per clock, to drive the analog output multiplexer. It also produces the control levels for the analog front end: a hold control shared by all pixels except the last, a separate hold control for the last pixel, and an active-low clear strobe for the integration capacitors.

The last pixel's hold line trails the shared line by one clock. This lets the whole array be presented in as many clocks as it has pixels. A start request that arrives before the last pixel is reached restarts the index at pixel 1. The restart keeps the values already held, and the integration capacitors are not cleared again. When a readout completes and no new start follows, the block falls idle: the index parks on pixel 1, nothing is held, and a tracking flag tells the analog side that pixel 1 is shown live.

The reset input asserts asynchronously and is released through a configurable synchroniser. The clear strobe comes from a register clocked on the falling edge, so its edges fall on falling clock edges.

Top module: `lss_readout_seq`

## Requirements
- R1: While `arst_n` is low, and for the first two rising edges after it rises, the block is held in reset: `pix_sel_o` = 1, `hold_bank_o` = 0, `hold_tail_o` = 0, `integ_clr_n_o` = 0, `busy_o` = 0, `track_o` = 1. Any start request seen during this time is ignored.
- R2: `start_i` = 1 at a rising edge while idle begins a readout: `pix_sel_o` = 1, `busy_o` = 1 and `hold_bank_o` = 1 after that edge.
- R3: `hold_tail_o` takes the value `hold_bank_o` had before each rising edge, so it lags the shared hold line by exactly one clock.
- R4: After the rising edge that begins a new readout, `integ_clr_n_o` is low from the 2nd following falling edge until the 3rd, and high at all other times outside reset.
- R5: During a readout without restart, `pix_sel_o` advances by one on each rising edge, from 1 up to 256 (the pixel count).
- R6: `hold_bank_o` falls to 0 at the edge where `pix_sel_o` goes from 255 to 256, and `hold_tail_o` falls one edge later.
- R7: `start_i` = 1 at a rising edge while busy with `pix_sel_o` below 256 restarts the index at 1. Both hold lines keep their levels, no new clear strobe is issued, and the release of the hold lines is timed from the restart.
- R8: `start_i` = 1 at the edge where `pix_sel_o` shows 256 begins a full new readout, with `hold_bank_o` set again and a new clear strobe.
- R9: At the edge after pixel 256 with no start request, the block goes idle: `pix_sel_o` = 1, `busy_o` = 0, both hold lines 0, `track_o` = 1. It stays so until the next start request.
- R10: `start_i` is sampled only at rising edges; a pulse that rises and falls between two rising edges has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| arst_n | input | 1 | Active-low reset, asynchronous assert, synchronised release |
| start_i | input | 1 | Start request, sampled at rising edges |
| pix_sel_o | output | 9 | Selected pixel, 1 to 256 |
| hold_bank_o | output | 1 | Hold control, all pixels except the last (1 = hold) |
| hold_tail_o | output | 1 | Hold control, last pixel (1 = hold) |
| integ_clr_n_o | output | 1 | Integration clear, active low, changes on falling edges |
| busy_o | output | 1 | Readout in progress |
| track_o | output | 1 | Idle, pixel 1 shown live without hold |

## Verification
A start request can land in the same cycle as the stepping of the index, the release of the hold lines or the end of the readout. The question in each case is whether it counts as a restart (index below 256) or a new readout (index 256 or idle). Directed cases put a start at pixel 5, at pixel 256 and on a glitch between edges. Random start densities then press requests against every phase of the sequence, including the clear strobe window. Every cycle the index, both hold lines, the strobe and the flags are compared with a cycle-accurate bench model.

// File: rtl/lss_pkg.sv
package lss_pkg;

   // action chosen for the coming rising edge
   typedef enum logic [2:0] {
      ACT_IDLE    = 3'd0,
      ACT_NEW     = 3'd1,
      ACT_RESTART = 3'd2,
      ACT_STEP    = 3'd3,
      ACT_FINISH  = 3'd4
   } seq_act_e;

endpackage

// File: rtl/lss_rst_sync.sv
module lss_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n_o
);

   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("lss_rst_sync: STAGES must be 0 to 4");
   end

   if (STAGES == 0) begin : g_direct
      assign rst_n_o = arst_n;
   end else if (STAGES == 1) begin : g_single
      logic sr_q;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) sr_q <= 1'b0;
         else         sr_q <= 1'b1;
      end
      assign rst_n_o = sr_q;
   end else begin : g_chain
      logic [STAGES-1:0] sr_q;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) sr_q <= '0;
         else         sr_q <= {sr_q[STAGES-2:0], 1'b1};
      end
      assign rst_n_o = sr_q[STAGES-1];
   end

endmodule

// File: rtl/lss_pix_counter.sv
module lss_pix_counter
   import lss_pkg::*;
#(
   parameter int NUM_PIX = 256,
   parameter int IDX_W   = $clog2(NUM_PIX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic [IDX_W-1:0] cnt_o,
   output logic             busy_o,
   output logic             fresh_o,
   output seq_act_e         act_o
);

   localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_PIX);

   logic [IDX_W-1:0] cnt_q;
   logic             busy_q;
   logic             fresh_q;
   seq_act_e         act;

   always_comb begin
      if (start_i) begin
         act = (busy_q && cnt_q != IDX_LAST) ? ACT_RESTART : ACT_NEW;
      end else if (busy_q) begin
         act = (cnt_q == IDX_LAST) ? ACT_FINISH : ACT_STEP;
      end else begin
         act = ACT_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= IDX_ONE;
         busy_q  <= 1'b0;
         fresh_q <= 1'b0;
      end else begin
         unique case (act)
            ACT_NEW: begin
               cnt_q   <= IDX_ONE;
               busy_q  <= 1'b1;
               fresh_q <= 1'b1;
            end
            ACT_RESTART: begin
               cnt_q   <= IDX_ONE;
               fresh_q <= 1'b0;
            end
            ACT_STEP:   cnt_q <= cnt_q + IDX_ONE;
            ACT_FINISH: begin
               cnt_q  <= IDX_ONE;
               busy_q <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   assign cnt_o   = cnt_q;
   assign busy_o  = busy_q;
   assign fresh_o = fresh_q;
   assign act_o   = act;

   // R5: index stays in 1..NUM_PIX
   p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q >= IDX_ONE) && (cnt_q <= IDX_LAST));

   // R5: an uninterrupted readout advances by one
   p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !start_i && cnt_q != IDX_LAST) |=> (cnt_q == $past(cnt_q) + IDX_ONE));

   // R2 / R7: any start request restarts the index at pixel 1
   p_start_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (cnt_q == IDX_ONE && busy_q));

endmodule

// File: rtl/lss_hold_ctrl.sv
module lss_hold_ctrl
   import lss_pkg::*;
#(
   parameter int NUM_PIX = 256,
   parameter int IDX_W   = $clog2(NUM_PIX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  seq_act_e         act_i,
   input  logic [IDX_W-1:0] cnt_i,
   output logic             hold_bank_o,
   output logic             hold_tail_o
);

   localparam logic [IDX_W-1:0] IDX_PEN = IDX_W'(NUM_PIX - 1);

   logic bank_q;
   logic tail_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= 1'b0;
         tail_q <= 1'b0;
      end else begin
         tail_q <= bank_q;
         if (act_i == ACT_NEW) begin
            bank_q <= 1'b1;
         end else if (act_i == ACT_STEP && cnt_i == IDX_PEN) begin
            bank_q <= 1'b0;
         end
      end
   end

   assign hold_bank_o = bank_q;
   assign hold_tail_o = tail_q;

   // R7: a restart leaves both hold lines where they were
   p_restart_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == ACT_RESTART) |=> (bank_q && tail_q == $past(tail_q) || bank_q && $past(bank_q) && tail_q));

endmodule

// File: rtl/lss_integ_clr.sv
module lss_integ_clr #(
   parameter int NUM_PIX  = 256,
   parameter int IDX_W    = $clog2(NUM_PIX + 1),
   parameter int CLR_FALL = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy_i,
   input  logic             fresh_i,
   input  logic [IDX_W-1:0] cnt_i,
   output logic             clr_n_o
);

   localparam logic [IDX_W-1:0] CLR_AT = IDX_W'(CLR_FALL);

   logic clr_n_q;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) clr_n_q <= 1'b0;
      else        clr_n_q <= !(busy_i && fresh_i && cnt_i == CLR_AT);
   end

   assign clr_n_o = clr_n_q;

   // R4: the clear strobe only appears in the window of a fresh readout
   p_clr_fresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n_q |-> (busy_i && fresh_i && cnt_i == CLR_AT));

endmodule

// File: rtl/lss_readout_seq.sv
module lss_readout_seq
   import lss_pkg::*;
#(
   parameter int NUM_PIX     = 256,
   parameter int CLR_FALL    = 2,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = $clog2(NUM_PIX + 1)
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             start_i,
   output logic [IDX_W-1:0] pix_sel_o,
   output logic             hold_bank_o,
   output logic             hold_tail_o,
   output logic             integ_clr_n_o,
   output logic             busy_o,
   output logic             track_o
);

   if (NUM_PIX < 4 || NUM_PIX > 4096) begin : g_bad_pix
      $error("lss_readout_seq: NUM_PIX must be 4 to 4096");
   end
   if (CLR_FALL < 1 || CLR_FALL >= NUM_PIX - 1) begin : g_bad_clr
      $error("lss_readout_seq: CLR_FALL must lie inside the readout");
   end

   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_PIX);

   logic             rst_i;
   logic [IDX_W-1:0] cnt;
   logic             busy;
   logic             fresh;
   seq_act_e         act;
   logic             bank;
   logic             tail;

   lss_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
      .clk     (clk),
      .arst_n  (arst_n),
      .rst_n_o (rst_i)
   );

   lss_pix_counter #(.NUM_PIX(NUM_PIX), .IDX_W(IDX_W)) u_counter (
      .clk     (clk),
      .rst_n   (rst_i),
      .start_i (start_i),
      .cnt_o   (cnt),
      .busy_o  (busy),
      .fresh_o (fresh),
      .act_o   (act)
   );

   lss_hold_ctrl #(.NUM_PIX(NUM_PIX), .IDX_W(IDX_W)) u_hold (
      .clk         (clk),
      .rst_n       (rst_i),
      .act_i       (act),
      .cnt_i       (cnt),
      .hold_bank_o (bank),
      .hold_tail_o (tail)
   );

   lss_integ_clr #(.NUM_PIX(NUM_PIX), .IDX_W(IDX_W), .CLR_FALL(CLR_FALL)) u_clr (
      .clk     (clk),
      .rst_n   (rst_i),
      .busy_i  (busy),
      .fresh_i (fresh),
      .cnt_i   (cnt),
      .clr_n_o (integ_clr_n_o)
   );

   assign pix_sel_o   = cnt;
   assign hold_bank_o = bank;
   assign hold_tail_o = tail;
   assign busy_o      = busy;
   assign track_o     = !busy && !tail;

   // R6: pixels 1..N-1 stay held for the whole readout
   p_bank_held_r6: assert property (@(posedge clk) disable iff (!rst_i)
      (busy && cnt != IDX_LAST) |-> bank);

   // R9: nothing is held while idle
   p_idle_sample_r9: assert property (@(posedge clk) disable iff (!rst_i)
      !busy |-> (!bank && cnt == IDX_W'(1)));

endmodule

// File: tb/test_lss_readout_seq.sv
module test_lss_readout_seq;

   localparam int NPIX = 256;

   logic       clk = 1'b0;
   logic       arst_n;
   logic       start;
   logic [8:0] pix;
   logic       bank, tail, clr_n, busy, track;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   lss_readout_seq i_lss_readout_seq (
      .clk           (clk),
      .arst_n        (arst_n),
      .start_i       (start),
      .pix_sel_o     (pix),
      .hold_bank_o   (bank),
      .hold_tail_o   (tail),
      .integ_clr_n_o (clr_n),
      .busy_o        (busy),
      .track_o       (track)
   );

   // bench model of the requirements
   int m_cnt;
   bit m_busy, m_fresh, m_bank, m_tail, m_clr_n, m_s1, m_s2;

   function automatic void m_reset_state();
      m_cnt = 1; m_busy = 0; m_fresh = 0; m_bank = 0; m_tail = 0;
   endfunction

   function automatic void m_rise(input bit s);
      bit in_rst;
      if (!arst_n) begin
         m_s1 = 0; m_s2 = 0; m_reset_state();
         return;
      end
      in_rst = !m_s2;
      m_s2 = m_s1;
      m_s1 = 1;
      if (in_rst) begin
         m_reset_state();
         return;
      end
      m_tail = m_bank;
      if (s) begin
         if (m_busy && m_cnt < NPIX) begin
            m_cnt = 1; m_fresh = 0;
         end else begin
            m_cnt = 1; m_busy = 1; m_fresh = 1; m_bank = 1;
         end
      end else if (m_busy) begin
         if (m_cnt == NPIX) begin
            m_busy = 0; m_cnt = 1;
         end else begin
            if (m_cnt == NPIX - 1) m_bank = 0;
            m_cnt = m_cnt + 1;
         end
      end
   endfunction

   function automatic void m_fall();
      if (!m_s2) m_clr_n = 0;
      else       m_clr_n = !(m_busy && m_fresh && m_cnt == 2);
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk("R5 pixel index", int'(pix), m_cnt);
      chk("R6 shared hold", int'(bank), int'(m_bank));
      chk("R3 last-pixel hold", int'(tail), int'(m_tail));
      chk("R4 integration clear", int'(clr_n), int'(m_clr_n));
      chk("R9 busy", int'(busy), int'(m_busy));
      chk("R9 tracking", int'(track), int'(!m_busy && !m_tail));
   endtask

   // one clock: drive, rising edge, falling edge, sample late in the cycle
   task automatic step(input bit s);
      start = s;
      @(posedge clk);
      m_rise(s);
      @(negedge clk);
      m_fall();
      #3;
      compare();
   endtask

   task automatic run_to(input int target);
      for (int i = 0; i < 2000 && pix != 9'(target); i++) step(1'b0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      arst_n = 1'b0;
      start  = 1'b0;
      m_s1 = 0; m_s2 = 0; m_reset_state(); m_clr_n = 0;
      #2;
      chk("R1 clear during reset", int'(clr_n), 0);
      for (int i = 0; i < 3; i++) step(1'b1);
      chk("R1 idle in reset", int'(busy), 0);
      chk("R1 track in reset", int'(track), 1);
      arst_n = 1'b1;
      step(1'b1);
      step(1'b1);
      chk("R1 start ignored during release", int'(busy), 0);
      chk("R1 index after release", int'(pix), 1);
      step(1'b0);

      // normal readout
      step(1'b1);
      chk("R2 index at start", int'(pix), 1);
      chk("R2 busy at start", int'(busy), 1);
      chk("R2 shared hold at start", int'(bank), 1);
      chk("R3 tail still sampling", int'(tail), 0);
      chk("R4 no clear at 1st fall", int'(clr_n), 1);
      step(1'b0);
      chk("R3 tail holds one clock later", int'(tail), 1);
      chk("R4 clear low at 2nd fall", int'(clr_n), 0);
      step(1'b0);
      chk("R4 clear high at 3rd fall", int'(clr_n), 1);
      run_to(NPIX);
      chk("R5 reached last pixel", int'(pix), NPIX);
      chk("R6 shared hold released", int'(bank), 0);
      chk("R6 tail still held", int'(tail), 1);
      step(1'b0);
      chk("R9 idle index", int'(pix), 1);
      chk("R9 tracking", int'(track), 1);
      for (int i = 0; i < 300; i++) step(1'b0);
      chk("R9 long idle index", int'(pix), 1);
      chk("R9 long idle no hold", int'(tail), 0);

      // restart at pixel 5
      step(1'b1);
      run_to(5);
      step(1'b1);
      chk("R7 restart index", int'(pix), 1);
      chk("R7 shared hold kept", int'(bank), 1);
      chk("R7 tail hold kept", int'(tail), 1);
      step(1'b0);
      step(1'b0);
      chk("R7 no clear after restart", int'(clr_n), 1);
      run_to(NPIX - 1);
      chk("R7 hold kept to pixel 255", int'(bank), 1);
      step(1'b0);
      chk("R7 release timed from restart", int'(bank), 0);

      // start exactly at the last pixel
      step(1'b1);
      chk("R8 new readout index", int'(pix), 1);
      chk("R8 shared hold set again", int'(bank), 1);
      step(1'b0);
      chk("R8 new clear strobe", int'(clr_n), 0);
      run_to(NPIX);
      step(1'b0);

      // glitch between edges
      start = 1'b1;
      #1;
      start = 1'b0;
      step(1'b0);
      chk("R10 glitch ignored busy", int'(busy), 0);
      chk("R10 glitch ignored hold", int'(bank), 0);

      // random phases with different start densities
      for (int ph = 0; ph < 4; ph++) begin
         int dens;
         dens = (ph == 0) ? 40 : (ph == 1) ? 5 : (ph == 2) ? 1 : 0;
         for (int i = 0; i < 1500; i++) begin
            if (dens == 0) step(($urandom_range(0, 599) == 0));
            else           step(($urandom_range(0, 999) < dens));
         end
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule